// File: doc/BRIEF.md
# Register-Programmed Watchdog Timer

This block is a watchdog countdown timer that software programs and services over a small byte-wide register bus. One control byte holds a time-out multiplier, a resolution select and a steering bit. Writing that byte loads the countdown and restarts it. If software fails to write it again before the count runs out, the timer expires. The steering bit routes the expiry either to a one-cycle reset request or to an active-low interrupt line. That line is shared with an external frequency-test square wave and an external alarm request.

A sticky status bit records every expiry and is cleared by reading it. Writing zero to the control byte disables the timer and releases the interrupt. A power-fail indication forces the same disabled, zeroed state. The timer advances only on a prescaled tick supplied from outside. Each resolution step multiplies the tick count per unit by four.

Top module: `wdt_top`

## Requirements
- R1: Writing the control byte at address 1 reloads the countdown, with bits 6:2 as the multiplier M and bits 1:0 as the resolution r. With the tick high every cycle, expiry appears exactly M·4^r clock edges after the write edge.
- R2: When bit 7 of the control byte is 0 (reset steering), each expiry raises `resetReq` for exactly one cycle, and the countdown reloads from the stored byte so that the next expiry follows M·4^r ticks later.
- R3: When bit 7 is 1 (interrupt steering), an expiry drives `irqFtN` low. It stays low through nonzero writes and is released only by writing 00h or by power-fail.
- R4: Writing 00h, or any byte whose multiplier field is zero, disables the timer, and no expiry occurs after that.
- R5: Bit 7 of the status register at address 0 is set on expiry. A read of address 0 returns it in `busRdata` one cycle later and clears it.
- R6: If a status read and an expiry fall in the same cycle, the status bit remains set afterwards.
- R7: While `powerFail` is high, the control byte is forced to 00h, the interrupt is released and control-byte writes are ignored.
- R8: While bit 7 of the control byte is 1 or `alarmReq` is high, `freqWave` cannot reach `irqFtN`, and the pin is low exactly when the watchdog interrupt or `alarmReq` is active. Otherwise `irqFtN` follows `freqWave`.
- R9: A control-byte write in the same cycle as an expiry wins: that expiry is dropped and the countdown restarts.
- R10: After reset the control byte and status bit are zero, `resetReq` is low and `busRdata` is 00h.
- R11: A read of address 1 returns the control byte one cycle later. Reads of other addresses, and cycles without a read, return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled timebase pulse |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | 8 | Write data |
| powerFail | input | 1 | Power-fail indication |
| alarmReq | input | 1 | External alarm interrupt request |
| freqWave | input | 1 | External frequency-test square wave |
| irqFtN | output | 1 | Shared active-low interrupt / frequency-test pin |
| resetReq | output | 1 | One-cycle reset request |
| busRdata | output | 8 | Registered read data |

## Verification
Several rules are checked by the assertions on every cycle:
- a reset request only follows a tick while reset steering is selected;
- the interrupt is released only by a zero write or by power-fail;
- the alarm and a latched interrupt under interrupt steering always own the pin;
- power-fail leaves the control byte at zero;
- a status read clears the bit unless an expiry coincides with it, and an expiry always leaves it set;
- a zero multiplier never expires.

The exact time-out lengths for each resolution, the reload and period of reset pulses, and the service write that collides with an expiry can only be shown by the bench's timed scenarios. The same holds for read-data contents and for the freeze of writes during power-fail. All of these are compared against a tick-level reference model under random traffic.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTRL_W     = 8;
  localparam int STEER_BIT  = 7;
  localparam int MULT_HI    = 6;
  localparam int MULT_LO    = 2;
  localparam int MULT_W     = MULT_HI - MULT_LO + 1;
  localparam int RES_HI     = 1;
  localparam int RES_LO     = 0;
  localparam int RES_W      = RES_HI - RES_LO + 1;
  localparam int STATUS_BIT = 7;

  typedef enum logic {
    STEER_RESET = 1'b0,
    STEER_IRQ   = 1'b1
  } steer_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic              clearReg;   // power-fail: zero everything
    logic              writeReg;   // software write of the control byte
    logic              reloadCnt;  // reset-steered expiry: restart from stored byte
    logic [CTRL_W-1:0] wrData;
  } wdt_strobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int RES_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  wdt_strobe_t       strobe,
  output logic [CTRL_W-1:0] regQ,
  output logic              expireNow
);
  localparam int RES_CNT = 1 << RES_W;
  localparam int PRE_W   = RES_SHIFT * (RES_CNT - 1);

  logic [PRE_W-1:0]  limits [RES_CNT];
  logic [MULT_W-1:0] cntQ;
  logic [PRE_W-1:0]  preQ;
  logic [RES_W-1:0]  resSel;
  logic              atLimit;
  logic              running;

  // terminal prescaler value for each resolution: 4^g - 1 ticks
  for (genvar g = 0; g < RES_CNT; g++) begin : g_lim
    assign limits[g] = PRE_W'((64'd1 << (RES_SHIFT * g)) - 64'd1);
  end

  assign resSel    = regQ[RES_HI:RES_LO];
  assign atLimit   = (preQ == limits[resSel]);
  assign running   = (cntQ != '0);
  assign expireNow = tick && running && atLimit && (cntQ == MULT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ <= '0;
      cntQ <= '0;
      preQ <= '0;
    end else if (strobe.clearReg) begin
      regQ <= '0;
      cntQ <= '0;
      preQ <= '0;
    end else if (strobe.writeReg) begin
      regQ <= strobe.wrData;
      cntQ <= strobe.wrData[MULT_HI:MULT_LO];
      preQ <= '0;
    end else if (strobe.reloadCnt) begin
      cntQ <= regQ[MULT_HI:MULT_LO];
      preQ <= '0;
    end else if (tick && running) begin
      if (atLimit) begin
        cntQ <= cntQ - MULT_W'(1);
        preQ <= '0;
      end else begin
        preQ <= preQ + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int FLAG_ADDR = 0,
  parameter int WDOG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CTRL_W-1:0] busWdata,
  input  logic              powerFail,
  input  logic              alarmReq,
  input  logic              freqWave,
  input  logic [CTRL_W-1:0] regQ,
  input  logic              expireNow,
  output wdt_strobe_t       strobe,
  output logic              expireEff,
  output logic              irqQ,
  output logic              flagQ,
  output logic              resetReq,
  output logic              irqFtN,
  output logic [CTRL_W-1:0] busRdata
);
  localparam logic [ADDR_W-1:0] FlagA = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] WdogA = ADDR_W'(WDOG_ADDR);

  logic   wrHit, wrZero, rdFlag, pinOwned;
  steer_e steer;

  assign steer = steer_e'(regQ[STEER_BIT]);

  always_comb begin
    wrHit     = busWr && (busAddr == WdogA) && !powerFail;
    wrZero    = wrHit && (busWdata == '0);
    rdFlag    = busRd && (busAddr == FlagA);
    expireEff = expireNow && !powerFail && !wrHit;

    strobe.clearReg  = powerFail;
    strobe.writeReg  = wrHit;
    strobe.reloadCnt = expireEff && (steer == STEER_RESET);
    strobe.wrData    = busWdata;
  end

  // watchdog or alarm owns the shared pin; frequency test only when free
  assign pinOwned = (steer == STEER_IRQ) || alarmReq;
  assign irqFtN   = pinOwned ? !(irqQ || alarmReq) : freqWave;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ     <= 1'b0;
      flagQ    <= 1'b0;
      resetReq <= 1'b0;
      busRdata <= '0;
    end else begin
      if (powerFail || wrZero)
        irqQ <= 1'b0;
      else if (expireEff && (steer == STEER_IRQ))
        irqQ <= 1'b1;

      if (expireEff)
        flagQ <= 1'b1;
      else if (rdFlag)
        flagQ <= 1'b0;

      resetReq <= expireEff && (steer == STEER_RESET);

      if (!busRd)
        busRdata <= '0;
      else if (busAddr == FlagA)
        busRdata <= CTRL_W'({flagQ, {STATUS_BIT{1'b0}}});
      else if (busAddr == WdogA)
        busRdata <= regQ;
      else
        busRdata <= '0;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int FLAG_ADDR = 0,
  parameter int WDOG_ADDR = 1,
  parameter int RES_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              powerFail,
  input  logic              alarmReq,
  input  logic              freqWave,
  output logic              irqFtN,
  output logic              resetReq,
  output logic [7:0]        busRdata
);
  wdt_strobe_t       strobe;
  logic [CTRL_W-1:0] regQ;
  logic              expireNow;
  logic              expireEff;
  logic              irqQ;
  logic              flagQ;

  wdt_datapath #(.RES_SHIFT(RES_SHIFT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .strobe    (strobe),
    .regQ      (regQ),
    .expireNow (expireNow)
  );

  wdt_ctrl #(
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR),
    .WDOG_ADDR (WDOG_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busRd     (busRd),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .powerFail (powerFail),
    .alarmReq  (alarmReq),
    .freqWave  (freqWave),
    .regQ      (regQ),
    .expireNow (expireNow),
    .strobe    (strobe),
    .expireEff (expireEff),
    .irqQ      (irqQ),
    .flagQ     (flagQ),
    .resetReq  (resetReq),
    .irqFtN    (irqFtN),
    .busRdata  (busRdata)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int ADDR_W    = 2,
  parameter int FLAG_ADDR = 0,
  parameter int WDOG_ADDR = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              busWr,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              powerFail,
  input logic              alarmReq,
  input logic              irqFtN,
  input logic              resetReq,
  input logic              irqQ,
  input logic              flagQ,
  input logic              wdSteer,
  input logic [4:0]        wdMult,
  input logic              expireEff
);
  localparam logic [ADDR_W-1:0] FlagA = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] WdogA = ADDR_W'(WDOG_ADDR);

  assert_reset_needs_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(tick));

  assert_reset_steer_R2: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(!wdSteer));

  assert_irq_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqQ) |-> $past(powerFail || (busWr && busAddr == WdogA && busWdata == 8'h00)));

  assert_irq_owns_pin_R3: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && wdSteer) |-> !irqFtN);

  assert_zero_mult_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wdMult == 5'd0) |-> !expireEff);

  assert_flag_read_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == FlagA && !expireEff) |=> !flagQ);

  assert_flag_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    expireEff |=> flagQ);

  assert_powerfail_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> (wdMult == 5'd0 && !wdSteer && !irqQ));

  assert_alarm_owns_pin_R8: assert property (@(posedge clk) disable iff (!rstN)
    alarmReq |-> !irqFtN);
endmodule

bind wdt_top wdt_checker #(
  .ADDR_W    (ADDR_W),
  .FLAG_ADDR (FLAG_ADDR),
  .WDOG_ADDR (WDOG_ADDR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .busWr     (busWr),
  .busRd     (busRd),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .powerFail (powerFail),
  .alarmReq  (alarmReq),
  .irqFtN    (irqFtN),
  .resetReq  (resetReq),
  .irqQ      (irqQ),
  .flagQ     (flagQ),
  .wdSteer   (regQ[7]),
  .wdMult    (regQ[6:2]),
  .expireEff (expireEff)
);

// File: tb/wdt_top_bench.sv
`timescale 1ns/1ps
module wdt_top_bench;
  localparam int FL = 0;
  localparam int WD = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'h00;
  logic       powerFail = 1'b0;
  logic       alarmReq = 1'b0;
  logic       freqWave = 1'b1;
  logic       irqFtN;
  logic       resetReq;
  logic [7:0] busRdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  wdt_top u_wdt_top (
    .clk(clk), .rstN(rstN), .tick(tick), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .powerFail(powerFail),
    .alarmReq(alarmReq), .freqWave(freqWave), .irqFtN(irqFtN),
    .resetReq(resetReq), .busRdata(busRdata)
  );

  // ---------------- reference model, built from the requirements ----------
  logic [7:0] mReg;
  logic       mIrq, mFlag, mRst;
  logic [7:0] mRdata;
  int         mLeft;

  function automatic int spanOf(logic [7:0] v);
    return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
  endfunction

  function automatic logic expPin(logic [7:0] r, logic irq, logic alarm, logic fw);
    if (r[7] || alarm) return !(irq || alarm);
    return fw;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mReg = 8'h00; mIrq = 1'b0; mFlag = 1'b0; mRst = 1'b0; mRdata = 8'h00; mLeft = 0;
    end else begin
      logic wr, rdF, ex;
      wr  = busWr && busAddr == 2'(WD) && !powerFail;
      rdF = busRd && busAddr == 2'(FL);
      ex  = !powerFail && !wr && tick && mLeft == 1;
      if (!busRd) mRdata = 8'h00;
      else if (busAddr == 2'(FL)) mRdata = {mFlag, 7'd0};
      else if (busAddr == 2'(WD)) mRdata = mReg;
      else mRdata = 8'h00;
      mRst = ex && !mReg[7];
      if (ex) mFlag = 1'b1; else if (rdF) mFlag = 1'b0;
      if (powerFail) begin
        mReg = 8'h00; mLeft = 0; mIrq = 1'b0;
      end else if (wr) begin
        mReg = busWdata; mLeft = spanOf(busWdata);
        if (busWdata == 8'h00) mIrq = 1'b0;
      end else if (ex) begin
        if (mReg[7]) begin mIrq = 1'b1; mLeft = 0; end
        else mLeft = spanOf(mReg);
      end else if (tick && mLeft != 0) begin
        mLeft = mLeft - 1;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cycle-level comparison, 1 ns after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (rstN && !done) begin
      check("R8", "pin vs model", int'(irqFtN), int'(expPin(mReg, mIrq, alarmReq, freqWave)));
      check("R2", "resetReq vs model", int'(resetReq), int'(mRst));
      check("R11", "rdata vs model", int'(busRdata), int'(mRdata));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wrReg(int addr, logic [7:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = 2'(addr); busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdReg(int addr, output logic [7:0] d);
    @(negedge clk); busRd = 1'b1; busAddr = 2'(addr);
    @(negedge clk); busRd = 1'b0; d = busRdata;
  endtask

  task automatic waitEvent(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); n++;
      if (resetReq || !irqFtN) break;
    end
  endtask

  task automatic idleCount(int cyc, output int hits);
    hits = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (resetReq || !irqFtN) hits++;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", "resetReq after reset", int'(resetReq), 0);
    check("R10", "pin after reset", int'(irqFtN), 1);
    rdReg(WD, rd); check("R10", "control byte after reset", int'(rd), 0);
    rdReg(FL, rd); check("R10", "status after reset", int'(rd), 0);
    rdReg(2, rd);  check("R11", "unmapped read", int'(rd), 0);

    tick = 1'b1;
    // R1: time-out length at each resolution, R11 readback
    wrReg(WD, 8'h0C); waitEvent(n); check("R1", "M3 r0 latency", n, 3);
    rdReg(WD, rd); check("R11", "control byte readback", int'(rd), 'h0C);
    wrReg(WD, 8'h09); waitEvent(n); check("R1", "M2 r1 latency", n, 8);
    wrReg(WD, 8'h06); waitEvent(n); check("R1", "M1 r2 latency", n, 16);
    wrReg(WD, 8'h07); waitEvent(n); check("R1", "M1 r3 latency", n, 64);
    // R2: reload after reset pulse, pulse one cycle wide
    wrReg(WD, 8'h0C); waitEvent(n); check("R2", "first pulse", n, 3);
    waitEvent(n); check("R2", "reload period", n, 3);
    wrReg(WD, 8'h00);
    // R5: flag set and cleared by read
    rdReg(FL, rd); check("R5", "flag after expiries", int'(rd), 'h80);
    rdReg(FL, rd); check("R5", "flag after read", int'(rd), 'h00);
    // R6: read colliding with expiry
    wrReg(WD, 8'h08);
    @(negedge clk); busRd = 1'b1; busAddr = 2'(FL);
    @(negedge clk); busRd = 1'b0;
    check("R6", "resetReq in collision", int'(resetReq), 1);
    check("R6", "old flag returned", int'(busRdata), 'h00);
    rdReg(FL, rd); check("R6", "flag kept set", int'(rd), 'h80);
    wrReg(WD, 8'h00);
    // R9: service write colliding with expiry
    wrReg(WD, 8'h08);
    @(negedge clk); busWr = 1'b1; busAddr = 2'(WD); busWdata = 8'h08;
    @(negedge clk); busWr = 1'b0;
    check("R9", "expiry dropped", int'(resetReq), 0);
    waitEvent(n); check("R9", "restart latency", n, 2);
    wrReg(WD, 8'h00);
    // R3: interrupt held through nonzero write, released by 00h
    wrReg(WD, 8'h84); waitEvent(n); check("R3", "irq latency", n, 1);
    wrReg(WD, 8'hFC);
    check("R3", "irq held after nonzero write", int'(irqFtN), 0);
    wrReg(WD, 8'h00);
    check("R3", "irq released by 00h", int'(irqFtN), 1);
    // R4: disabled states
    idleCount(300, n); check("R4", "no expiry after 00h", n, 0);
    wrReg(WD, 8'h03);
    idleCount(300, n); check("R4", "no expiry with zero multiplier", n, 0);
    // R7: power-fail
    wrReg(WD, 8'h88); waitEvent(n); check("R7", "irq before power-fail", int'(irqFtN), 0);
    @(negedge clk); powerFail = 1'b1;
    @(negedge clk);
    check("R7", "irq released by power-fail", int'(irqFtN), 1);
    wrReg(WD, 8'h0C);
    powerFail = 1'b0;
    rdReg(WD, rd); check("R7", "write ignored during power-fail", int'(rd), 0);
    // R8: pin ownership
    tick = 1'b0;
    wrReg(WD, 8'hFF);
    freqWave = 1'b0; @(negedge clk);
    check("R8", "wave blocked by steering", int'(irqFtN), 1);
    alarmReq = 1'b1; @(negedge clk);
    check("R8", "alarm drives pin", int'(irqFtN), 0);
    alarmReq = 1'b0;
    wrReg(WD, 8'h00);
    check("R8", "wave passes when free", int'(irqFtN), 0);
    freqWave = 1'b1; @(negedge clk);
    check("R8", "wave high passes", int'(irqFtN), 1);

    // random traffic, checked cycle by cycle against the model
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      tick      = ($urandom % 3) != 0;
      busWr     = ($urandom % 40) == 0;
      busAddr   = 2'($urandom % 3);
      busWdata  = (($urandom % 8) == 0) ? 8'h00 :
                  {1'($urandom), 5'($urandom % 6), 2'($urandom % 2)};
      busRd     = ($urandom % 10) == 0;
      powerFail = ($urandom % 400) == 0;
      if (($urandom % 50) == 0) alarmReq = !alarmReq;
      if (($urandom % 4) == 0) freqWave = !freqWave;
    end
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0; powerFail = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule